// File: doc/BRIEF.md
# Fast-Data Scan Completion Chain

This block is the JTAG data-register path that a debug probe selects with a dedicated TAP instruction to move words quickly between itself and a stalled CPU. The path is 33 bits long. A 32-bit data word sits nearest to TDI and a single status bit sits nearest to TDO. One scan through it both asks for the CPU's pending access to be completed and reports whether that completion was legal. The probe does not need a separate control-register write to release the CPU.

On the CPU side, the block holds one pending access at a time: its address, its direction (load or store) and, for a store, the stored word. At Capture-DR, the status bit is loaded with the success predicate: an access is pending and its address falls in a 16-byte fast-transfer window. The data word is loaded with the pending store data, or with zero for a load. At Update-DR, the completion is applied if the probe shifted in a 0 as the status bit and the captured predicate was true. Completion clears the pending flag, pulses a done strobe and, for a load, returns the shifted-in word. Shifting in a 1 as the status bit only probes: the status shifted out still tells whether the access would have succeeded.

Top module: `fdx_scan_chain`

## Requirements
- R1: The chain is 33 bits long. The bit leaving TDO first after a capture is the status bit, followed by data bits 0 to 31. The bit entering first from TDI ends up as the status input, and the next 32 bits become data bits 0 to 31.
- R2: At capture, the status bit is 1 exactly when an access is pending and its address lies in 0xFF200000..0xFF20000F inclusive.
- R3: At capture, the data word is the pending store word for a store access (acc_store=1), and 0 otherwise.
- R4: An update with status input 0 and a captured status of 1 clears acc_pending at that edge. It also raises acc_done for exactly the following cycle.
- R5: When a load access (acc_store=0) completes, acc_rdata takes the 32 data bits shifted in. It holds that value until the next completed load.
- R6: An update with status input 1 completes nothing. acc_pending stays set and acc_done stays low.
- R7: An access whose address lies outside the window reports status 0 and is never completed, even when completion is requested.
- R8: A scan with no access pending reports status 0 and produces no acc_done.
- R9: A new acc_valid while an access is pending is ignored. The held address and direction are kept.
- R10: After reset, acc_pending, acc_done, acc_rdata and tdo are all 0.
- R11: An access that becomes pending after the capture of a scan is not completed by that scan's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dr_sel | input | 1 | Fast-data instruction is selected in the TAP |
| dr_capture | input | 1 | TAP is in Capture-DR |
| dr_shift | input | 1 | TAP is in Shift-DR |
| dr_update | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (status bit end of the chain) |
| acc_valid | input | 1 | CPU raises a new access into the window region |
| acc_addr | input | 32 | Address of the new access |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_wdata | input | 32 | Store data of the new access |
| acc_pending | output | 1 | An access is waiting for the probe |
| acc_done | output | 1 | One-cycle pulse: the pending access completed |
| acc_rdata | output | 32 | Word returned to a completed load |

## Verification
On every cycle, the assertions check four properties. The first tdo bit after a capture equals the captured predicate. A done pulse is always preceded by a pending, in-window access. A pending access is never dropped without a completion. A held access is never overwritten by a new request. Only the bench's scenarios can show the behaviour of a whole scan: the serial bit order, loads getting the shifted-in word, stores appearing in the shifted-out word, probe-only scans, the window edges, and the case of an access that arrives mid-scan. These are compared cycle by cycle against a queue-based model.

// File: rtl/fdx_pkg.sv
package fdx_pkg;
   typedef enum logic {
      FDX_LOAD  = 1'b0,
      FDX_STORE = 1'b1
   } fdx_dir_e;
endpackage

// File: rtl/fdx_window.sv
module fdx_window #(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 32'hFF20_0000,
   parameter int                WIN_BYTES = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam bit IS_POW2 = (WIN_BYTES & (WIN_BYTES - 1)) == 0;

   if (WIN_BYTES < 1) begin : g_bad_size
      $error("fdx_window: WIN_BYTES must be at least 1");
   end

   if (IS_POW2 && ((WIN_BASE & ADDR_W'(WIN_BYTES - 1)) == '0)) begin : g_mask
      localparam logic [ADDR_W-1:0] MASK = ~ADDR_W'(WIN_BYTES - 1);
      assign hit = (addr & MASK) == WIN_BASE;
   end else begin : g_range
      localparam logic [ADDR_W:0] LIMIT = {1'b0, WIN_BASE} + (ADDR_W+1)'(WIN_BYTES);
      assign hit = (addr >= WIN_BASE) && ({1'b0, addr} < LIMIT);
   end
endmodule

// File: rtl/fdx_pending.sv
module fdx_pending
   import fdx_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  fdx_dir_e          req_dir,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              complete,
   output logic              pend,
   output logic [ADDR_W-1:0] pend_addr,
   output fdx_dir_e          pend_dir,
   output logic [DATA_W-1:0] pend_wdata
);
   logic take;
   assign take = req_valid && !pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend       <= 1'b0;
         pend_addr  <= '0;
         pend_dir   <= FDX_LOAD;
         pend_wdata <= '0;
      end else begin
         if (complete) begin
            pend <= 1'b0;
         end else if (take) begin
            pend       <= 1'b1;
            pend_addr  <= req_addr;
            pend_dir   <= req_dir;
            pend_wdata <= req_wdata;
         end
      end
   end

   assert_hold_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !complete) |=> pend);

   assert_keep_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && req_valid) |=> ($stable(pend_addr) && $stable(pend_dir)));
endmodule

// File: rtl/fdx_shifter.sv
module fdx_shifter #(
   parameter int LEN = 33
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           capture,
   input  logic           shift,
   input  logic           ser_in,
   input  logic [LEN-1:0] par_in,
   output logic [LEN-1:0] par_q,
   output logic           ser_out
);
   if (LEN < 2) begin : g_bad_len
      $error("fdx_shifter: LEN must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= '0;
      end else if (capture) begin
         par_q <= par_in;
      end else if (shift) begin
         par_q <= {ser_in, par_q[LEN-1:1]};
      end
   end

   assign ser_out = par_q[0];

   assert_first_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (ser_out == $past(par_in[0])));
endmodule

// File: rtl/fdx_scan_chain.sv
module fdx_scan_chain
   import fdx_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                DATA_W    = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 32'hFF20_0000,
   parameter int                WIN_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dr_sel,
   input  logic              dr_capture,
   input  logic              dr_shift,
   input  logic              dr_update,
   input  logic              tdi,
   output logic              tdo,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_store,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic              acc_pending,
   output logic              acc_done,
   output logic [DATA_W-1:0] acc_rdata
);
   localparam int CHAIN_W = DATA_W + 1;

   if (DATA_W < 1) begin : g_bad_data
      $error("fdx_scan_chain: DATA_W must be at least 1");
   end

   logic              pend;
   logic [ADDR_W-1:0] pend_addr;
   fdx_dir_e          pend_dir;
   logic [DATA_W-1:0] pend_wdata;
   logic              win_hit;
   logic              ok_now;
   logic              cap_ok_q;
   logic              do_cap, do_shift, do_upd, complete;
   logic [CHAIN_W-1:0] cap_word;
   logic [CHAIN_W-1:0] chain_q;

   assign do_cap   = dr_sel && dr_capture;
   assign do_shift = dr_sel && dr_shift && !dr_capture;
   assign do_upd   = dr_sel && dr_update && !dr_capture && !dr_shift;
   assign ok_now   = pend && win_hit;
   assign complete = do_upd && !chain_q[0] && cap_ok_q;

   fdx_window #(
      .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
   ) i_window (
      .addr(pend_addr),
      .hit (win_hit)
   );

   fdx_pending #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) i_pending (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (acc_valid),
      .req_addr  (acc_addr),
      .req_dir   (fdx_dir_e'(acc_store)),
      .req_wdata (acc_wdata),
      .complete  (complete),
      .pend      (pend),
      .pend_addr (pend_addr),
      .pend_dir  (pend_dir),
      .pend_wdata(pend_wdata)
   );

   assign cap_word = {(pend_dir == FDX_STORE) ? pend_wdata : '0, ok_now};

   fdx_shifter #(
      .LEN(CHAIN_W)
   ) i_shifter (
      .clk    (clk),
      .rst_n  (rst_n),
      .capture(do_cap),
      .shift  (do_shift),
      .ser_in (tdi),
      .par_in (cap_word),
      .par_q  (chain_q),
      .ser_out(tdo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_ok_q  <= 1'b0;
         acc_done  <= 1'b0;
         acc_rdata <= '0;
      end else begin
         acc_done <= complete;
         if (do_cap) begin
            cap_ok_q <= ok_now;
         end else if (complete) begin
            cap_ok_q <= 1'b0;
         end
         if (complete && pend_dir == FDX_LOAD) begin
            acc_rdata <= chain_q[CHAIN_W-1:1];
         end
      end
   end

   assign acc_pending = pend;

   assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_done |-> !acc_pending);

   assert_done_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_done |-> $past(pend && win_hit));

   assert_probe_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (do_upd && chain_q[0]) |=> !acc_done);
endmodule

// File: tb/test_fdx_scan_chain.sv
module test_fdx_scan_chain;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
   logic        tdo;
   logic        acc_valid = 1'b0, acc_store = 1'b0;
   logic [31:0] acc_addr = '0, acc_wdata = '0;
   logic        acc_pending, acc_done;
   logic [31:0] acc_rdata;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   fdx_scan_chain i_fdx_scan_chain (
      .clk(clk), .rst_n(rst_n), .dr_sel(sel), .dr_capture(cap), .dr_shift(sh),
      .dr_update(upd), .tdi(tdi), .tdo(tdo), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_store(acc_store), .acc_wdata(acc_wdata),
      .acc_pending(acc_pending), .acc_done(acc_done), .acc_rdata(acc_rdata)
   );

   // behavioural reference model
   bit          m_pend, m_store, m_capok, m_done, was_pend;
   logic [31:0] m_addr, m_wd, m_rdata;
   bit          m_q[$];

   function automatic bit in_win(logic [31:0] a);
      return (a >= 32'hFF20_0000) && (a <= 32'hFF20_000F);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pend = 0; m_capok = 0; m_done = 0; m_rdata = '0; m_store = 0;
         m_addr = '0; m_wd = '0;
         m_q.delete();
         for (int i = 0; i < 33; i++) m_q.push_back(1'b0);
      end else begin
         was_pend = m_pend;
         m_done = 0;
         if (sel && cap) begin
            m_capok = m_pend && in_win(m_addr);
            m_q.delete();
            m_q.push_back(m_capok);
            for (int i = 0; i < 32; i++) m_q.push_back(m_store ? m_wd[i] : 1'b0);
         end else if (sel && sh) begin
            void'(m_q.pop_front());
            m_q.push_back(tdi);
         end else if (sel && upd && m_q[0] == 1'b0 && m_capok) begin
            m_pend = 0; m_capok = 0; m_done = 1;
            if (!m_store) for (int i = 0; i < 32; i++) m_rdata[i] = m_q[i+1];
         end
         if (acc_valid && !was_pend) begin
            m_pend = 1; m_addr = acc_addr; m_store = acc_store; m_wd = acc_wdata;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // compare against model on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R1 tdo", {31'b0, tdo}, {31'b0, m_q[0]});
         chk("R4 pending", {31'b0, acc_pending}, {31'b0, m_pend});
         chk("R4 done", {31'b0, acc_done}, {31'b0, m_done});
         chk("R5 rdata", acc_rdata, m_rdata);
      end
   end

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic raise(input logic [31:0] a, input bit st, input logic [31:0] wd);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_store = st; acc_wdata = wd;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic scan(input bit st_in, input logic [31:0] din, input int late_at,
                       input logic [31:0] late_addr,
                       output bit st_out, output logic [31:0] dout, output bit done);
      @(negedge clk);
      sel = 1'b1; cap = 1'b1;
      @(negedge clk);
      cap = 1'b0; sh = 1'b1;
      for (int i = 0; i < 33; i++) begin
         tdi = (i == 0) ? st_in : din[i-1];
         if (i == 0) st_out = tdo; else dout[i-1] = tdo;
         acc_valid = (i == late_at);
         acc_addr  = late_addr; acc_store = 1'b0;
         @(negedge clk);
      end
      acc_valid = 1'b0;
      sh = 1'b0; upd = 1'b1;
      @(negedge clk);
      upd = 1'b0; sel = 1'b0;
      done = acc_done;
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      bit so, dn;
      logic [31:0] dq;
      repeat (2) @(negedge clk);
      // R10 reset state
      chk("R10 pending", {31'b0, acc_pending}, 0);
      chk("R10 done", {31'b0, acc_done}, 0);
      chk("R10 rdata", acc_rdata, 0);
      chk("R10 tdo", {31'b0, tdo}, 0);
      rst_n = 1'b1;

      // R8 nothing pending
      scan(1'b0, 32'h1111_2222, -1, '0, so, dq, dn);
      chk("R8 status", {31'b0, so}, 0);
      chk("R8 done", {31'b0, dn}, 0);

      // load inside window: R2, R5, R4, R3 (load data zero)
      raise(32'hFF20_0004, 1'b0, 32'hFFFF_FFFF);
      scan(1'b0, 32'hA5A5_1234, -1, '0, so, dq, dn);
      chk("R2 status", {31'b0, so}, 1);
      chk("R3 load capture zero", dq, 0);
      chk("R4 done", {31'b0, dn}, 1);
      chk("R4 cleared", {31'b0, acc_pending}, 0);
      chk("R5 rdata", acc_rdata, 32'hA5A5_1234);

      // store, probe-only first: R6, R3
      raise(32'hFF20_000C, 1'b1, 32'hDEAD_BEEF);
      scan(1'b1, 32'h0, -1, '0, so, dq, dn);
      chk("R6 status", {31'b0, so}, 1);
      chk("R3 store data", dq, 32'hDEAD_BEEF);
      chk("R6 no done", {31'b0, dn}, 0);
      chk("R6 still pending", {31'b0, acc_pending}, 1);
      scan(1'b0, 32'h0, -1, '0, so, dq, dn);
      chk("R4 store done", {31'b0, dn}, 1);
      chk("R5 rdata kept on store", acc_rdata, 32'hA5A5_1234);

      // R2 upper window edge
      raise(32'hFF20_000F, 1'b0, 32'h0);
      scan(1'b0, 32'h0F0F_F0F0, -1, '0, so, dq, dn);
      chk("R2 edge status", {31'b0, so}, 1);
      chk("R5 edge rdata", acc_rdata, 32'h0F0F_F0F0);

      // R7 just above window
      raise(32'hFF20_0010, 1'b0, 32'h0);
      scan(1'b0, 32'h1234_5678, -1, '0, so, dq, dn);
      chk("R7 status", {31'b0, so}, 0);
      chk("R7 no done", {31'b0, dn}, 0);
      chk("R7 still pending", {31'b0, acc_pending}, 1);
      do_reset();
      chk("R10 after reset", {31'b0, acc_pending}, 0);

      // R7 just below window
      raise(32'hFF1F_FFFF, 1'b0, 32'h0);
      scan(1'b0, 32'h0, -1, '0, so, dq, dn);
      chk("R7 below status", {31'b0, so}, 0);
      do_reset();

      // R9 second request ignored
      raise(32'hFF20_0008, 1'b0, 32'h0);
      raise(32'h0000_1000, 1'b1, 32'hCAFE_0000);
      scan(1'b0, 32'h5555_AAAA, -1, '0, so, dq, dn);
      chk("R9 status kept", {31'b0, so}, 1);
      chk("R9 kept load", acc_rdata, 32'h5555_AAAA);

      // R11 access arrives mid-scan
      scan(1'b0, 32'h7777_7777, 5, 32'hFF20_0000, so, dq, dn);
      chk("R11 status", {31'b0, so}, 0);
      chk("R11 no done", {31'b0, dn}, 0);
      chk("R11 pending", {31'b0, acc_pending}, 1);
      scan(1'b0, 32'h8888_0001, -1, '0, so, dq, dn);
      chk("R11 later done", {31'b0, dn}, 1);
      chk("R1 order rdata", acc_rdata, 32'h8888_0001);

      repeat (3) @(negedge clk);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule